// File: doc/BRIEF.md
# Scatter-Gather Descriptor DMA Channel

This block is a single DMA channel that follows a chain of packed 8-byte descriptors held in memory. Each descriptor gives a buffer address and a byte count. For each descriptor the channel either writes words arriving on its 32-bit stream input into the buffer (receive build) or reads the buffer and presents the words on its 32-bit stream output (transmit build). A parameter picks the build. Descriptors sit back to back, so the channel steps its list pointer by 8 after each one. It stops after the descriptor that carries the end flag and then gives a one-cycle completion pulse.

Software uses a small register port to control the channel. One register holds the list pointer. A receive channel also has a run register and a row-length register. A transmit channel starts as soon as its list pointer is written. Memory is reached through a plain word port that allows one read in flight. Writes are taken in the cycle they are issued.

Top module: `dma_sg_channel`

## Requirements
- R1: After reset the channel is idle. busy_o, done_o, err_o, row_end_o, mem_req_o, rx_ready_o and tx_valid_o are all low.
- R2: A descriptor is fetched as two reads, first at the list pointer and then at the pointer plus 4. The first word holds the flags in bits 7:0 (bit 0 valid, bit 1 end of list, bit 5 transfer), reserved bits in 15:8 and the byte count in 31:16. The second word is the buffer address. The next descriptor is fetched at the pointer plus 8.
- R3: In the receive build, each accepted stream word is written to the buffer at consecutive word addresses, for count/4 words. The write appears on the memory port in the cycle after the beat is accepted.
- R4: In the transmit build, each buffer word is read in order and shown on tx_data_o with tx_valid_o. The word and tx_valid_o hold steady until tx_ready_i is seen.
- R5: done_o is a one-cycle pulse. It is given only once every byte of the end-flagged descriptor has moved. In the receive build it comes with the last memory write. In the transmit build it comes in the cycle after the last stream handshake.
- R6: A descriptor whose count is not a multiple of 4 sets err_o and halts the walk. No data moves and done_o stays low.
- R7: A descriptor whose valid bit is clear sets err_o and halts the walk. No data moves.
- R8: A start clears err_o and begins a fetch at the list pointer. A receive channel starts on a write of 1 in bit 0 of the run register (offset 0x14). A transmit channel starts on a write to the list-pointer register (offset 0x04).
- R9: In the receive build, a write of 0 to the run register makes the channel idle in the next cycle. The descriptor in progress is dropped and done_o is not given.
- R10: In the receive build, row_end_o pulses in the cycle after each stream beat that completes a group of row-length bytes (offset 0x30). The count starts from zero at each start. A row length of 0 means no strobe.
- R11: A valid descriptor with a count of 0 moves nothing, and the walk goes on to the next descriptor.
- R12: A write to the high-address register (offset 0x00) has no effect on the addresses the channel fetches.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | RW | Register byte offset |
| reg_wdata | input | DW | Register write data |
| mem_req_o | output | 1 | Memory request, one cycle per access |
| mem_we_o | output | 1 | Memory access is a write |
| mem_addr_o | output | AW | Memory byte address |
| mem_wdata_o | output | DW | Memory write data |
| mem_rvalid_i | input | 1 | Read data valid |
| mem_rdata_i | input | DW | Read data |
| rx_valid_i | input | 1 | Receive stream word valid |
| rx_data_i | input | DW | Receive stream word |
| rx_ready_o | output | 1 | Channel accepts a receive word |
| tx_valid_o | output | 1 | Transmit stream word valid |
| tx_data_o | output | DW | Transmit stream word |
| tx_ready_i | input | 1 | Sink accepts the transmit word |
| busy_o | output | 1 | Channel is walking a list |
| done_o | output | 1 | Completion pulse |
| err_o | output | 1 | Bad descriptor seen since the last start |
| row_end_o | output | 1 | Row boundary strobe (receive build) |

## Verification
Each result has a fixed cycle in which it must appear:
- **Memory writes and row strobes:** a write and any row strobe appear one cycle after the stream beat that causes them.
- **Receive completion:** the completion pulse comes with the final write.
- **Transmit completion:** the completion pulse comes one cycle after the final transmit handshake.
- **Stop and error:** the channel is idle one cycle after a stop, and an error shows once the second descriptor word has returned.

The bench runs a behavioural model that predicts these events from its own queues of expected reads, writes and stream words. At every falling edge it compares the design's memory requests, row strobe and completion pulse with what the model predicts for that cycle. An access that comes early, comes late or was not expected is therefore reported in the cycle it happens.

// File: rtl/dma_sg_pkg.sv
package dma_sg_pkg;

  localparam int CNT_W      = 16;
  localparam int DESC_BYTES = 8;
  localparam int WORD_BYTES = 4;

  localparam int OFS_LIST_HI = 'h00;
  localparam int OFS_LIST_LO = 'h04;
  localparam int OFS_RUN     = 'h14;
  localparam int OFS_ROW     = 'h30;

  localparam int FLG_VALID = 0;
  localparam int FLG_LAST  = 1;
  localparam int FLG_XFER  = 5;

  typedef enum logic [3:0] {
    S_IDLE, S_F0, S_W0, S_F1, S_W1, S_RX, S_TXRD, S_TXW, S_TXO
  } chan_state_t;

  typedef struct packed {
    logic             ok;
    logic             last;
    logic             xfer;
    logic             aligned;
    logic             rsvd_zero;
    logic [CNT_W-1:0] count;
  } desc_info_t;

endpackage

// File: rtl/dma_sg_desc_decode.sv
module dma_sg_desc_decode
  import dma_sg_pkg::*;
(
  input  logic [31:0] word_i,
  output desc_info_t  info_o
);
  always_comb begin
    info_o.ok        = word_i[FLG_VALID];
    info_o.last      = word_i[FLG_LAST];
    info_o.xfer      = word_i[FLG_XFER];
    info_o.rsvd_zero = (word_i[15:8] == 8'h00) && (word_i[4:2] == 3'b000) && (word_i[7:6] == 2'b00);
    info_o.count     = word_i[31:16];
    info_o.aligned   = (word_i[17:16] == 2'b00);
  end
endmodule

// File: rtl/dma_sg_row_tracker.sv
module dma_sg_row_tracker #(
  parameter int ROW_W = 16,
  parameter int STEP  = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             clear_i,
  input  logic             beat_i,
  input  logic [ROW_W-1:0] row_bytes_i,
  output logic             row_end_o
);
  logic [ROW_W-1:0] cnt_q;
  logic [ROW_W:0]   next_sum;

  assign next_sum = {1'b0, cnt_q} + (ROW_W+1)'(STEP);

  always_ff @(posedge clk) begin
    if (rst || clear_i) begin
      cnt_q     <= '0;
      row_end_o <= 1'b0;
    end else begin
      row_end_o <= 1'b0;
      if (beat_i) begin
        if (row_bytes_i != '0 && next_sum >= {1'b0, row_bytes_i}) begin
          row_end_o <= 1'b1;
          cnt_q     <= '0;
        end else begin
          cnt_q <= next_sum[ROW_W-1:0];
        end
      end
    end
  end

  // R10: a strobe only ever follows an accepted beat
  a_r10_strobe_follows_beat: assert property (@(posedge clk) disable iff (rst)
    row_end_o |-> $past(beat_i));

endmodule

// File: rtl/dma_sg_channel.sv
module dma_sg_channel
  import dma_sg_pkg::*;
#(
  parameter bit IS_RX = 1'b1,
  parameter int AW    = 32,
  parameter int DW    = 32,
  parameter int RW    = 8,
  parameter int ROW_W = 16
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          reg_we,
  input  logic [RW-1:0] reg_addr,
  input  logic [DW-1:0] reg_wdata,
  output logic          mem_req_o,
  output logic          mem_we_o,
  output logic [AW-1:0] mem_addr_o,
  output logic [DW-1:0] mem_wdata_o,
  input  logic          mem_rvalid_i,
  input  logic [DW-1:0] mem_rdata_i,
  input  logic          rx_valid_i,
  input  logic [DW-1:0] rx_data_i,
  output logic          rx_ready_o,
  output logic          tx_valid_o,
  output logic [DW-1:0] tx_data_o,
  input  logic          tx_ready_i,
  output logic          busy_o,
  output logic          done_o,
  output logic          err_o,
  output logic          row_end_o
);
  localparam logic [CNT_W-1:0] WB    = CNT_W'(WORD_BYTES);
  localparam logic [AW-1:0]    A_WB  = AW'(WORD_BYTES);
  localparam logic [AW-1:0]    A_DSC = AW'(DESC_BYTES);

  chan_state_t      state_q;
  logic [AW-1:0]    list_ptr_q, buf_q;
  logic [31:0]      w0_q;
  logic [CNT_W-1:0] remain_q;
  logic             last_q;
  logic [ROW_W-1:0] row_bytes_q;
  desc_info_t       info;

  logic wr_lo, wr_run, wr_row, start, stop, rx_beat;

  assign wr_lo  = reg_we && (reg_addr == RW'(OFS_LIST_LO));
  assign wr_run = reg_we && (reg_addr == RW'(OFS_RUN)) && IS_RX;
  assign wr_row = reg_we && (reg_addr == RW'(OFS_ROW)) && IS_RX;
  assign start  = IS_RX ? (wr_run && reg_wdata[0]) : wr_lo;
  assign stop   = wr_run && !reg_wdata[0];

  assign busy_o     = (state_q != S_IDLE);
  assign rx_ready_o = IS_RX && (state_q == S_RX);
  assign rx_beat    = rx_ready_o && rx_valid_i;

  dma_sg_desc_decode u_dec (
    .word_i (w0_q),
    .info_o (info)
  );

  dma_sg_row_tracker #(.ROW_W(ROW_W), .STEP(WORD_BYTES)) u_row (
    .clk         (clk),
    .rst         (rst),
    .clear_i     (start),
    .beat_i      (rx_beat),
    .row_bytes_i (row_bytes_q),
    .row_end_o   (row_end_o)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q     <= S_IDLE;
      list_ptr_q  <= '0;
      buf_q       <= '0;
      w0_q        <= '0;
      remain_q    <= '0;
      last_q      <= 1'b0;
      row_bytes_q <= '0;
      mem_req_o   <= 1'b0;
      mem_we_o    <= 1'b0;
      mem_addr_o  <= '0;
      mem_wdata_o <= '0;
      tx_valid_o  <= 1'b0;
      tx_data_o   <= '0;
      done_o      <= 1'b0;
      err_o       <= 1'b0;
    end else begin
      mem_req_o <= 1'b0;
      done_o    <= 1'b0;
      if (wr_lo)  list_ptr_q  <= reg_wdata[AW-1:0];
      if (wr_row) row_bytes_q <= reg_wdata[ROW_W-1:0];
      if (start) begin
        state_q    <= S_F0;
        err_o      <= 1'b0;
        tx_valid_o <= 1'b0;
      end else if (stop) begin
        state_q    <= S_IDLE;
        tx_valid_o <= 1'b0;
      end else begin
        unique case (state_q)
          S_F0: begin
            mem_req_o  <= 1'b1;
            mem_we_o   <= 1'b0;
            mem_addr_o <= list_ptr_q;
            state_q    <= S_W0;
          end
          S_W0: if (mem_rvalid_i) begin
            w0_q    <= mem_rdata_i[31:0];
            state_q <= S_F1;
          end
          S_F1: begin
            mem_req_o  <= 1'b1;
            mem_we_o   <= 1'b0;
            mem_addr_o <= list_ptr_q + A_WB;
            state_q    <= S_W1;
          end
          S_W1: if (mem_rvalid_i) begin
            if (!info.ok || !info.aligned) begin
              err_o   <= 1'b1;
              state_q <= S_IDLE;
            end else begin
              buf_q      <= mem_rdata_i[AW-1:0];
              remain_q   <= info.count;
              last_q     <= info.last;
              list_ptr_q <= list_ptr_q + A_DSC;
              if (info.count == '0) begin
                done_o  <= info.last;
                state_q <= info.last ? S_IDLE : S_F0;
              end else begin
                state_q <= IS_RX ? S_RX : S_TXRD;
              end
            end
          end
          S_RX: if (rx_valid_i) begin
            mem_req_o   <= 1'b1;
            mem_we_o    <= 1'b1;
            mem_addr_o  <= buf_q;
            mem_wdata_o <= rx_data_i;
            buf_q       <= buf_q + A_WB;
            remain_q    <= remain_q - WB;
            if (remain_q == WB) begin
              done_o  <= last_q;
              state_q <= last_q ? S_IDLE : S_F0;
            end
          end
          S_TXRD: begin
            mem_req_o  <= 1'b1;
            mem_we_o   <= 1'b0;
            mem_addr_o <= buf_q;
            buf_q      <= buf_q + A_WB;
            state_q    <= S_TXW;
          end
          S_TXW: if (mem_rvalid_i) begin
            tx_data_o  <= mem_rdata_i;
            tx_valid_o <= 1'b1;
            state_q    <= S_TXO;
          end
          S_TXO: if (tx_ready_i) begin
            tx_valid_o <= 1'b0;
            remain_q   <= remain_q - WB;
            if (remain_q == WB) begin
              done_o  <= last_q;
              state_q <= last_q ? S_IDLE : S_F0;
            end else begin
              state_q <= S_TXRD;
            end
          end
          default: state_q <= S_IDLE;
        endcase
      end
    end
  end

  // R5: completion is a single-cycle pulse
  a_r5_done_single: assert property (@(posedge clk) disable iff (rst)
    done_o |=> !done_o);

  // R2: a read is never followed by another request in the next cycle
  a_r2_one_read: assert property (@(posedge clk) disable iff (rst)
    (mem_req_o && !mem_we_o) |=> !mem_req_o);

  // R6 / R7: the error flag only rises at the end of an active walk
  a_r6_err_from_walk: assert property (@(posedge clk) disable iff (rst)
    $rose(err_o) |-> $past(busy_o));

  // R4: an offered word holds until the sink takes it
  a_r4_tx_hold: assert property (@(posedge clk) disable iff (rst)
    (tx_valid_o && !tx_ready_i && !start) |=> (tx_valid_o && $stable(tx_data_o)));

  // R1: memory port stays quiet while idle, apart from a last write or read
  a_r1_idle_quiet: assert property (@(posedge clk) disable iff (rst)
    (!busy_o && !$past(busy_o)) |-> !mem_req_o);

endmodule

// File: tb/tb_dma_sg_channel.sv
module tb_dma_sg_channel;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0;
  logic rst = 1'b1;
  always #(CLK_PERIOD/2) clk = ~clk;

  int nchk = 0;
  int nfail = 0;

  // receive instance signals
  logic        r_we = 0;
  logic [7:0]  r_addr = 0;
  logic [31:0] r_wd = 0;
  logic        r_mreq, r_mwe, r_rv, r_rdy, r_tv, r_busy, r_done, r_err, r_row;
  logic [31:0] r_maddr, r_mwd, r_rd, r_td;
  logic        rx_valid = 0;
  logic [31:0] rx_data = 0;

  // transmit instance signals
  logic        t_we = 0;
  logic [7:0]  t_addr = 0;
  logic [31:0] t_wd = 0;
  logic        t_mreq, t_mwe, t_rv, t_rdy, t_tv, t_busy, t_done, t_err, t_row;
  logic [31:0] t_maddr, t_mwd, t_rd, t_td;
  logic        t_ready = 0;

  dma_sg_channel #(.IS_RX(1'b1)) dut (
    .clk(clk), .rst(rst), .reg_we(r_we), .reg_addr(r_addr), .reg_wdata(r_wd),
    .mem_req_o(r_mreq), .mem_we_o(r_mwe), .mem_addr_o(r_maddr), .mem_wdata_o(r_mwd),
    .mem_rvalid_i(r_rv), .mem_rdata_i(r_rd),
    .rx_valid_i(rx_valid), .rx_data_i(rx_data), .rx_ready_o(r_rdy),
    .tx_valid_o(r_tv), .tx_data_o(r_td), .tx_ready_i(1'b1),
    .busy_o(r_busy), .done_o(r_done), .err_o(r_err), .row_end_o(r_row));

  dma_sg_channel #(.IS_RX(1'b0)) dut_tx (
    .clk(clk), .rst(rst), .reg_we(t_we), .reg_addr(t_addr), .reg_wdata(t_wd),
    .mem_req_o(t_mreq), .mem_we_o(t_mwe), .mem_addr_o(t_maddr), .mem_wdata_o(t_mwd),
    .mem_rvalid_i(t_rv), .mem_rdata_i(t_rd),
    .rx_valid_i(1'b0), .rx_data_i(32'h0), .rx_ready_o(t_rdy),
    .tx_valid_o(t_tv), .tx_data_o(t_td), .tx_ready_i(t_ready),
    .busy_o(t_busy), .done_o(t_done), .err_o(t_err), .row_end_o(t_row));

  // shared memory model, one-cycle read latency
  logic [31:0] mem [0:255];
  logic        pl_we = 0;
  logic [31:0] pl_addr = 0, pl_data = 0;

  always @(posedge clk) begin
    r_rv <= 1'b0;
    t_rv <= 1'b0;
    if (pl_we) mem[pl_addr[9:2]] <= pl_data;
    if (r_mreq) begin
      if (r_mwe) mem[r_maddr[9:2]] <= r_mwd;
      else begin r_rv <= 1'b1; r_rd <= mem[r_maddr[9:2]]; end
    end
    if (t_mreq && !t_mwe) begin
      t_rv <= 1'b1;
      t_rd <= mem[t_maddr[9:2]];
    end
  end

  task automatic chk(input bit ok, input string rq, input logic [31:0] act, input logic [31:0] exp);
    nchk++;
    if (!ok) begin
      nfail++;
      $display("FAIL %s act=%08h exp=%08h t=%0t", rq, act, exp, $time);
    end
  endtask

  // reference model state
  logic [31:0] r_rdq[$], r_wq_a[$], r_wq_d[$], rx_src[$];
  logic [31:0] t_rdq[$], txq[$];
  bit  rx_exp_done = 0, tx_exp_done = 0;
  bit  rx_fire_prev = 0, tx_fire_prev = 0, tx_last_prev = 0;
  bit  feed_en = 1;
  int  m_row = 0, m_rowbytes = 0;
  int  r_done_cnt = 0, t_done_cnt = 0;

  always @(negedge clk) begin
    if (!rst) begin
      // receive side: memory port
      bit wrote, exp_row, exp_done;
      wrote = 0;
      if (r_mreq && r_mwe) begin
        wrote = 1;
        if (r_wq_a.size() == 0) chk(0, "R3 unexpected write", r_maddr, 32'h0);
        else begin
          chk(r_maddr == r_wq_a[0], "R3 write address", r_maddr, r_wq_a[0]);
          chk(r_mwd == r_wq_d[0], "R3 write data", r_mwd, r_wq_d[0]);
          void'(r_wq_a.pop_front()); void'(r_wq_d.pop_front());
        end
      end
      if (r_mreq && !r_mwe) begin
        if (r_rdq.size() == 0) chk(0, "R2 unexpected read", r_maddr, 32'h0);
        else begin
          chk(r_maddr == r_rdq[0], "R2 fetch address", r_maddr, r_rdq[0]);
          void'(r_rdq.pop_front());
        end
      end
      exp_done = wrote && (r_wq_a.size() == 0) && rx_exp_done;
      chk(r_done == exp_done, "R5 rx done timing", 32'(r_done), 32'(exp_done));
      if (r_done) r_done_cnt++;
      // R10 row strobe model
      exp_row = 0;
      if (rx_fire_prev) begin
        m_row += 4;
        if (m_rowbytes != 0 && m_row >= m_rowbytes) begin exp_row = 1; m_row = 0; end
      end
      chk(r_row == exp_row, "R10 row strobe", 32'(r_row), 32'(exp_row));
      // receive stream driver
      if (rx_fire_prev) void'(rx_src.pop_front());
      rx_valid = feed_en && (rx_src.size() > 0);
      rx_data  = (rx_src.size() > 0) ? rx_src[0] : 32'h0;
      rx_fire_prev = rx_valid && r_rdy;

      // transmit side
      if (t_mreq && !t_mwe) begin
        if (t_rdq.size() == 0) chk(0, "R2 tx unexpected read", t_maddr, 32'h0);
        else begin
          chk(t_maddr == t_rdq[0], "R2 tx read address", t_maddr, t_rdq[0]);
          void'(t_rdq.pop_front());
        end
      end
      chk(t_done == (tx_fire_prev && tx_last_prev), "R5 tx done timing",
          32'(t_done), 32'(tx_fire_prev && tx_last_prev));
      if (t_done) t_done_cnt++;
      t_ready = ~t_ready;
      tx_fire_prev = t_tv && t_ready;
      tx_last_prev = 0;
      if (tx_fire_prev) begin
        if (txq.size() == 0) chk(0, "R4 unexpected tx word", t_td, 32'h0);
        else begin
          chk(t_td == txq[0], "R4 tx data", t_td, txq[0]);
          void'(txq.pop_front());
          tx_last_prev = (txq.size() == 0) && tx_exp_done;
        end
      end
    end
  end

  task automatic poke(input logic [31:0] a, input logic [31:0] d);
    pl_we = 1; pl_addr = a; pl_data = d;
    @(posedge clk); @(negedge clk);
    pl_we = 0;
  endtask

  task automatic put_desc(input logic [31:0] at, input logic [7:0] flags,
                          input logic [15:0] cnt, input logic [31:0] buf_a);
    poke(at, {cnt, 8'h00, flags});
    poke(at + 4, buf_a);
  endtask

  task automatic rreg(input logic [7:0] a, input logic [31:0] d);
    if (a == 8'h14 && d[0]) m_row = 0;
    if (a == 8'h30) m_rowbytes = int'(d);
    r_we = 1; r_addr = a; r_wd = d;
    @(posedge clk); @(negedge clk);
    r_we = 0;
  endtask

  task automatic treg(input logic [7:0] a, input logic [31:0] d);
    t_we = 1; t_addr = a; t_wd = d;
    @(posedge clk); @(negedge clk);
    t_we = 0;
  endtask

  task automatic wait_rx_idle();
    for (int i = 0; i < 400; i++) begin
      if (!r_busy) break;
      @(negedge clk);
    end
  endtask

  task automatic wait_tx_idle();
    for (int i = 0; i < 400; i++) begin
      if (!t_busy) break;
      @(negedge clk);
    end
  endtask

  localparam logic [7:0] FV = 8'h01, FE = 8'h02, FT = 8'h20;

  initial begin
    repeat (5) @(negedge clk);
    rst = 0;
    @(negedge clk);
    // R1 reset state
    chk(!r_busy && !r_done && !r_err && !r_row && !r_mreq && !r_rdy && !r_tv,
        "R1 rx reset state", {25'h0, r_busy, r_done, r_err, r_row, r_mreq, r_rdy, r_tv}, 32'h0);
    chk(!t_busy && !t_done && !t_err && !t_mreq && !t_tv,
        "R1 tx reset state", {27'h0, t_busy, t_done, t_err, t_mreq, t_tv}, 32'h0);

    // R2 R3 R5 R10 R11 R12: three-entry chain with an empty middle entry
    put_desc(32'h100, FT | FV, 16'd12, 32'h200);
    put_desc(32'h108, FT | FV, 16'd0, 32'h240);
    put_desc(32'h110, FT | FV | FE, 16'd8, 32'h300);
    r_rdq = '{32'h100, 32'h104, 32'h108, 32'h10C, 32'h110, 32'h114};
    r_wq_a = '{32'h200, 32'h204, 32'h208, 32'h300, 32'h304};
    r_wq_d = '{32'hA0, 32'hA1, 32'hA2, 32'hA3, 32'hA4};
    rx_exp_done = 1;
    rreg(8'h30, 32'd8);
    rreg(8'h00, 32'h0000_00FF);   // R12 high address write is ignored
    rreg(8'h04, 32'h100);
    rreg(8'h14, 32'h1);
    rx_src = '{32'hA0, 32'hA1, 32'hA2, 32'hA3, 32'hA4};
    wait_rx_idle();
    repeat (3) @(negedge clk);
    chk(r_done_cnt == 1, "R5 one completion for chain", r_done_cnt, 1);
    chk(r_wq_a.size() == 0, "R3 all writes seen", r_wq_a.size(), 0);
    chk(r_rdq.size() == 0, "R11 walk passed empty entry", r_rdq.size(), 0);
    chk(r_err == 0, "R2 no error on good chain", 32'(r_err), 0);

    // R6 misaligned count
    put_desc(32'h140, FT | FV | FE, 16'd6, 32'h200);
    r_rdq = '{32'h140, 32'h144};
    rreg(8'h04, 32'h140);
    rreg(8'h14, 32'h1);
    wait_rx_idle();
    repeat (3) @(negedge clk);
    chk(r_err == 1, "R6 misaligned count flags error", 32'(r_err), 1);
    chk(r_done_cnt == 1, "R6 no completion", r_done_cnt, 1);

    // R7 valid bit clear
    put_desc(32'h150, FT, 16'd4, 32'h200);
    r_rdq = '{32'h150, 32'h154};
    rreg(8'h04, 32'h150);
    rreg(8'h14, 32'h1);
    chk(r_err == 0, "R8 start clears error", 32'(r_err), 0);
    wait_rx_idle();
    repeat (3) @(negedge clk);
    chk(r_err == 1, "R7 invalid entry flags error", 32'(r_err), 1);
    chk(r_done_cnt == 1, "R7 no completion", r_done_cnt, 1);

    // R8 restart and R10 strobe disabled
    put_desc(32'h160, FT | FV | FE, 16'd12, 32'h380);
    r_rdq = '{32'h160, 32'h164};
    r_wq_a = '{32'h380, 32'h384, 32'h388};
    r_wq_d = '{32'hC0, 32'hC1, 32'hC2};
    rreg(8'h30, 32'd0);
    rreg(8'h04, 32'h160);
    rreg(8'h14, 32'h1);
    chk(r_err == 0, "R8 restart clears error", 32'(r_err), 0);
    rx_src = '{32'hC0, 32'hC1, 32'hC2};
    wait_rx_idle();
    repeat (3) @(negedge clk);
    chk(r_done_cnt == 2, "R8 restarted chain completes", r_done_cnt, 2);

    // R9 abort mid-descriptor
    put_desc(32'h170, FT | FV | FE, 16'd16, 32'h3C0);
    r_rdq = '{32'h170, 32'h174};
    r_wq_a = '{32'h3C0, 32'h3C4};
    r_wq_d = '{32'hD0, 32'hD1};
    rx_exp_done = 0;
    rreg(8'h04, 32'h170);
    rreg(8'h14, 32'h1);
    rx_src = '{32'hD0, 32'hD1};
    for (int i = 0; i < 50; i++) begin
      if (r_wq_a.size() == 0) break;
      @(negedge clk);
    end
    feed_en = 0;
    repeat (3) @(negedge clk);
    chk(r_busy == 1, "R9 still waiting for data", 32'(r_busy), 1);
    rreg(8'h14, 32'h0);
    chk(r_busy == 0, "R9 stop makes channel idle", 32'(r_busy), 0);
    repeat (10) @(negedge clk);
    chk(r_done_cnt == 2, "R9 no completion after stop", r_done_cnt, 2);
    feed_en = 1;

    // R4 R5 R8 transmit chain, started by pointer write
    poke(32'h240, 32'hB0);
    poke(32'h244, 32'hB1);
    poke(32'h280, 32'hB2);
    put_desc(32'h180, FT | FV, 16'd8, 32'h240);
    put_desc(32'h188, FT | FV | FE, 16'd4, 32'h280);
    t_rdq = '{32'h180, 32'h184, 32'h240, 32'h244, 32'h188, 32'h18C, 32'h280};
    txq = '{32'hB0, 32'hB1, 32'hB2};
    tx_exp_done = 1;
    treg(8'h04, 32'h180);
    chk(t_busy == 1, "R8 tx starts on pointer write", 32'(t_busy), 1);
    wait_tx_idle();
    repeat (3) @(negedge clk);
    chk(t_done_cnt == 1, "R5 tx one completion", t_done_cnt, 1);
    chk(txq.size() == 0, "R4 all tx words seen", txq.size(), 0);
    chk(t_rdq.size() == 0, "R2 tx fetch sequence done", t_rdq.size(), 0);

    $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    nfail++;
    $display("FAIL watchdog expired");
    $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
    $finish;
  end

endmodule